// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block decides when a DRAM array needs a refresh and then carries out that refresh. A programmable down-counter, with an optional divide-by-64 stage in front of it, produces periodic refresh requests. A software trigger bit can also raise a single request, whether or not periodic refresh is enabled.

Only one request can be outstanding at a time. It is presented to the bus arbiter as a valid/ready pair: `ref_req` is the valid and `ref_gnt` is the ready. Once the grant is taken, the block drives a CAS-before-RAS sequence on the strobe outputs. It then clears the pending request itself.

Configuration arrives as a whole-register write, strobed by `cfg_we`. Every write reloads the interval counter and restarts the prescaler. Two low-power inputs select how the block behaves when the core is idle. In wait mode, periodic refresh continues. In stop mode, the counter is frozen and no periodic request is made. Nothing in the block checks the programmed interval against the RAS time-out limit; that is left to the software that programs it.

Top module: `refresh_gen`

## Requirements
- R1: After reset, `ref_req` is 0, `cas_n` is 1, all `ras_n` bits are 1 and `sw_busy` is 0. Periodic refresh is disabled and the prescaler is off.
- R2: With the prescaler off and enable set, a register write at clock edge W loads the rate value N. Periodic requests then occur at edges W+k·(N+1) for k = 1, 2, 3, and so on. `ref_req` rises right after each of those edges. N=0 means a request every cycle.
- R3: With the prescaler bit set, the interval becomes 64·(N+1) cycles, counted from the write.
- R4: While the enable bit is 0, the counter is held at its reload value and no periodic request is made.
- R5: Requests do not queue. A periodic event that occurs while a request is pending or being serviced is discarded. The pending state lasts from the request edge until the edge that ends the refresh.
- R6: A write with the trigger bit at 1 sets `sw_busy`. One edge later it raises one request, even when the enable bit is 0. `sw_busy` returns to 0 at the edge that ends that refresh. Writing the trigger bit as 0 leaves `sw_busy` unchanged.
- R7: A refresh of length L = 5 + `row_wait` cycles starts at the grant edge G. `cas_n` is low for L-1 cycles, starting right after G. All `ras_n` bits go low together one cycle after `cas_n`, and stay low for L-2 cycles. Both strobes are high in the last cycle, and the refresh ends at edge G+L.
- R8: `ref_req` stays high, unchanged, until it is accepted at an edge where `ref_gnt` is 1. It drops once the refresh starts.
- R9: `lp_wait` has no effect on request timing. While `lp_stop` is 1, the counter is held and no periodic request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_rate | input | 8 | Interval value N (divide ratio N+1) |
| cfg_prescale | input | 1 | 1 = add the divide-by-64 stage |
| cfg_enable | input | 1 | 1 = periodic refresh on |
| cfg_swtrig | input | 1 | 1 = request one software refresh |
| row_wait | input | 2 | Out-of-page wait field, sets the refresh length |
| lp_wait | input | 1 | Core is in wait mode |
| lp_stop | input | 1 | Core is in stop mode |
| ref_req | output | 1 | Refresh request (valid) to the arbiter |
| ref_gnt | input | 1 | Arbiter grant (ready) |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 4 | Row strobes for all banks, active low |
| sw_busy | output | 1 | Software trigger bit as read back |

## Verification
The assertions rely on three things about the inputs:
- `ref_gnt` is only meaningful while `ref_req` is high.
- `row_wait` does not change while a refresh is running.
- `lp_stop` is a level that masks the counter rather than a pulse.

The stimulus respects all three. It changes `row_wait` and the low-power pins only between scenarios, after the last refresh has finished. It holds `ref_gnt` at 1 except in one back-pressure window, where the grant is held off while a request waits. Each expected request edge is predicted from the write edge, the interval and the R5 drop rule before the scoreboard compares it.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int MIN_LEN = 5;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CAS, SQ_RAS, SQ_REL} seq_state_t;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int RATE_W  = 8,
  parameter int PRE_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] rate_q,
  input  logic              enable,
  input  logic              prescale,
  input  logic              stop,
  output logic              tick
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_DIV - 1);

  logic [RATE_W-1:0] cnt;
  logic [PRE_W-1:0]  pre;
  logic              running, step;

  assign running = enable && !stop;
  assign step    = !prescale || (pre == PRE_TOP);
  assign tick    = running && !reload && step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (reload) begin
      cnt <= new_rate;
      pre <= '0;
    end else if (!running) begin
      cnt <= rate_q;
      pre <= '0;
    end else begin
      if (prescale) pre <= (pre == PRE_TOP) ? '0 : pre + 1'b1;
      if (step) cnt <= (cnt == '0) ? rate_q : cnt - 1'b1;
    end
  end

  // R9: no periodic event while stopped
  assert_stop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !tick);
  // R4: no periodic event while disabled
  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick);
endmodule

// File: rtl/refresh_req.sv
module refresh_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_set,
  input  logic done,
  input  logic seq_idle,
  output logic req,
  output logic pend,
  output logic sw_busy
);
  logic pend_sw;

  assign req = pend && seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      pend_sw <= 1'b0;
      sw_busy <= 1'b0;
    end else begin
      if (sw_set) sw_busy <= 1'b1;
      else if (done && pend_sw) sw_busy <= 1'b0;
      if (done) begin
        pend    <= 1'b0;
        pend_sw <= 1'b0;
      end else if (!pend && (tick || sw_busy)) begin
        pend    <= 1'b1;
        pend_sw <= sw_busy;
      end
    end
  end

  // R5: a pending request is only retired by the end of its refresh
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done) |=> pend);
  // R6: trigger bit drops only after a finished refresh
  assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_busy) |-> $past(done));
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_pkg::*;
#(
  parameter int NUM_RAS = 4,
  parameter int WAIT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] row_wait,
  output logic              cas_n,
  output logic [NUM_RAS-1:0] ras_n,
  output logic              done,
  output logic              idle
);
  localparam int HOLD_W = $clog2(MIN_LEN + (1 << WAIT_W));

  seq_state_t        st;
  logic [HOLD_W-1:0] hold;
  logic              ras_on;

  assign idle   = (st == SQ_IDLE);
  assign done   = (st == SQ_REL);
  assign cas_n  = !((st == SQ_CAS) || (st == SQ_RAS));
  assign ras_on = (st == SQ_RAS);

  for (genvar g = 0; g < NUM_RAS; g++) begin : g_ras
    assign ras_n[g] = !ras_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      hold <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st   <= SQ_CAS;
          hold <= HOLD_W'(MIN_LEN - 3) + HOLD_W'(row_wait);
        end
        SQ_CAS:  st <= SQ_RAS;
        SQ_RAS:  if (hold == '0) st <= SQ_REL;
                 else hold <= hold - 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R7: row strobes fall only after the column strobe is already low
  assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> $past(!cas_n));
  assert_ras_under_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ras_n) |-> !cas_n);
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen
  import refresh_pkg::*;
#(
  parameter int RATE_W  = 8,
  parameter int PRE_DIV = 64,
  parameter int NUM_RAS = 4,
  parameter int WAIT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic               cfg_prescale,
  input  logic               cfg_enable,
  input  logic               cfg_swtrig,
  input  logic [WAIT_W-1:0]  row_wait,
  input  logic               lp_wait,
  input  logic               lp_stop,
  output logic               ref_req,
  input  logic               ref_gnt,
  output logic               cas_n,
  output logic [NUM_RAS-1:0] ras_n,
  output logic               sw_busy
);
  logic [RATE_W-1:0] rate_q;
  logic              pre_q, en_q;
  logic              tick, done, seq_idle, pend, start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      pre_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      rate_q <= cfg_rate;
      pre_q  <= cfg_prescale;
      en_q   <= cfg_enable;
    end
  end

  assign start = ref_req && ref_gnt;

  refresh_timer #(.RATE_W(RATE_W), .PRE_DIV(PRE_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(cfg_we), .new_rate(cfg_rate),
    .rate_q(rate_q), .enable(en_q), .prescale(pre_q), .stop(lp_stop),
    .tick(tick));

  refresh_req u_req (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_set(cfg_we && cfg_swtrig),
    .done(done), .seq_idle(seq_idle), .req(ref_req), .pend(pend),
    .sw_busy(sw_busy));

  refresh_seq #(.NUM_RAS(NUM_RAS), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .row_wait(row_wait),
    .cas_n(cas_n), .ras_n(ras_n), .done(done), .idle(seq_idle));

  // R8: request is held until accepted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  // R9: in wait mode a free periodic event is still latched
  assert_wait_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wait && tick && !pend) |=> pend);
endmodule

// File: tb/refresh_gen_tb.sv
module refresh_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_prescale = 1'b0, cfg_enable = 1'b0, cfg_swtrig = 1'b0;
  logic [7:0] cfg_rate = 8'd0;
  logic [1:0] row_wait = 2'd0;
  logic       lp_wait = 1'b0, lp_stop = 1'b0, ref_gnt = 1'b1;
  logic       ref_req, cas_n, sw_busy;
  logic [3:0] ras_n;

  int cyc = 0, checks = 0, errors = 0, cur_len = 5;
  int exp_q[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_gen u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rate(cfg_rate),
    .cfg_prescale(cfg_prescale), .cfg_enable(cfg_enable), .cfg_swtrig(cfg_swtrig),
    .row_wait(row_wait), .lp_wait(lp_wait), .lp_stop(lp_stop), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .cas_n(cas_n), .ras_n(ras_n), .sw_busy(sw_busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: request edges against the scoreboard queue
  logic req_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (ref_req && !req_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R4/R5/R9 unexpected request", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R2/R3/R5/R6 request edge", cyc, e);
      end
    end
    req_prev = ref_req;
  end

  // monitor: refresh strobe shape
  logic cas_prev = 1'b1;
  int cas_cnt = 0, ras_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (!cas_n) begin
      cas_cnt++;
      if (cas_prev) check(ras_n == 4'hF, "R7 CAS before RAS", ras_n, 15);
      if (ras_n != 4'hF) begin
        if (ras_n != 4'h0) check(1'b0, "R7 RAS lines together", ras_n, 0);
        ras_cnt++;
      end
    end else if (!cas_prev) begin
      check(cas_cnt == cur_len - 1, "R7 CAS low length", cas_cnt, cur_len - 1);
      check(ras_cnt == cur_len - 2, "R7 RAS low length", ras_cnt, cur_len - 2);
      cas_cnt = 0;
      ras_cnt = 0;
    end
    cas_prev = cas_n;
  end

  task automatic wr(input int rate, input bit pre, input bit en, input bit sw);
    cfg_rate = 8'(rate); cfg_prescale = pre; cfg_enable = en; cfg_swtrig = sw;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_swtrig = 1'b0;
  endtask

  // driver: program a periodic run, predict its request edges
  task automatic run_periodic(input int rate, input bit pre, input int rw,
                              input int win, input bit stopped, input string tag);
    int w, p, last;
    @(negedge clk);
    row_wait = 2'(rw);
    cur_len = 5 + rw;
    w = cyc + 1;
    p = (rate + 1) * (pre ? 64 : 1);
    last = -100000;
    if (!stopped)
      for (int t = w + p; t < w + win; t += p)
        if (t - last >= cur_len + 2) begin  // R5 drop rule
          exp_q.push_back(t);
          last = t;
        end
    wr(rate, pre, 1'b1, 1'b0);
    while (cyc < w + win - 1) @(negedge clk);
    wr(rate, pre, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ref_req == 1'b0, "R1 req after reset", ref_req, 0);
    check(cas_n == 1'b1 && ras_n == 4'hF, "R1 strobes after reset", {cas_n, ras_n}, 31);
    check(sw_busy == 1'b0, "R1 trigger bit after reset", sw_busy, 0);
    // R4 disabled out of reset: no request for 300 cycles
    repeat (300) @(negedge clk);
    check(exp_q.size() == 0 && !ref_req, "R4 idle while disabled", ref_req, 0);

    run_periodic(9, 1'b0, 0, 60, 1'b0, "R2 all requests seen, rate 9");
    run_periodic(0, 1'b0, 0, 30, 1'b0, "R5 drops at rate 0");
    run_periodic(1, 1'b1, 1, 300, 1'b0, "R3 prescaled requests");
    lp_wait = 1'b1;
    run_periodic(9, 1'b0, 3, 45, 1'b0, "R9 wait mode keeps requests");
    lp_wait = 1'b0;
    lp_stop = 1'b1;
    run_periodic(4, 1'b0, 0, 100, 1'b1, "R9 stop mode silent");
    lp_stop = 1'b0;

    // R6 / R8 software trigger with grant held off
    begin
      int w, g;
      bit held;
      row_wait = 2'd0;
      cur_len = 5;
      ref_gnt = 1'b0;
      @(negedge clk);
      w = cyc + 1;
      exp_q.push_back(w + 1);
      wr(0, 1'b0, 1'b0, 1'b1);
      check(sw_busy == 1'b1, "R6 trigger bit set", sw_busy, 1);
      held = 1'b1;
      while (cyc < w + 10) begin
        @(negedge clk);
        if (!ref_req) held = 1'b0;
      end
      check(held, "R8 request held without grant", held, 1);
      ref_gnt = 1'b1;
      g = w + 11;
      while (cyc < g + cur_len - 1) @(negedge clk);
      check(sw_busy == 1'b1, "R6 trigger bit during refresh", sw_busy, 1);
      @(negedge clk);
      check(sw_busy == 1'b0, "R6 trigger bit cleared at end", sw_busy, 0);
      // R6 writing trigger as 0 leaves it clear, no new request
      wr(0, 1'b0, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      check(sw_busy == 1'b0 && exp_q.size() == 0, "R6 single request only", sw_busy, 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule